// File: doc/BRIEF.md
# Dual Prescaled Interval Timers

Two 16-bit binary up-counters share one timer clock. Each counter has its own fixed prescaler: timer A steps once every `DIV_A` timer clocks and timer B once every `DIV_B` clocks. The defaults are 120 and 1200, which give 10 µs and 100 µs per step at 12 MHz. The step period scales directly with the timer clock frequency. Software loads, reads, starts and halts each counter through a small synchronous register port. Loading a counter also clears its prescaler, so a step never comes early.

When a running counter steps from FFFF hex to 0000 hex, the block sets that timer's bit in a sticky pending register and raises `irq_o`. The counter keeps running from zero. The time to the first timeout is therefore the number of steps from the loaded value up to zero. For example, loading FFFE hex gives two steps, which is 240 clocks for timer A. Software clears a pending bit by writing a one to it.

Register addresses on `addr_i`:

| Address | Meaning on write | Meaning on read |
|---|---|---|
| 0 | Load the timer A count | Timer A count |
| 1 | Load the timer B count | Timer B count |
| 2 | Commands, with one bit per action | Running flags |
| 3 | Write-one-to-clear for the pending bits | Pending bits |

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, both counts read 0, both timers are halted (address 2 reads 0), the pending register reads 0, and `irq_o` is low.
- R2: A write to address 0 or 1 loads that timer's count, and a read of the same address returns the value just written.
- R3: A running timer A increments its count by one every `DIV_A` clocks.
- R4: A running timer B increments its count by one every `DIV_B` clocks.
- R5: Loading a count clears that timer's prescaler. The first step therefore comes exactly `DIV` clocks after the start edge, or after the load edge when the timer is already running.
- R6: Halting freezes both the count and the prescaler. A later start resumes with the remaining part of the interrupted period.
- R7: A step from FFFF to 0000 sets the timer's pending bit (bit 0 for A, bit 1 for B) on the same edge, and the count then continues from 0.
- R8: A pending bit stays set until a write to address 3 has a one in that bit position. A zero in that position leaves the bit unchanged.
- R9: `irq_o` and `pend_o` reflect the pending register: `irq_o` is high exactly when any pending bit is set.
- R10: In a write to address 2, bit 0 starts A, bit 1 halts A, bit 2 starts B and bit 3 halts B; halt wins when both are set for a timer. A read of address 2 returns bit 0 as A running and bit 1 as B running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| pend_o | output | 2 | Pending timeout flags {B, A} |
| irq_o | output | 1 | Any timeout pending |

## Verification
Timer A is started from a value loaded while it was halted, and separately reloaded while it was running. Sampling the count one clock before and exactly on each expected step shows whether the prescaler is cleared on a load, and this exposes an off-by-one in the divide ratio. A halt partway through a period, followed by a restart, separates a frozen prescaler from one that keeps counting or restarts. Loading FFFE into each timer makes it wrap, which shows that the pending bits are set per timer. Writes to the pending register with ones and zeros in different positions test the clear-on-one behaviour. A command write that sets both start and halt for the same timer tests the halt-wins priority.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned NUM_TMR = 2;

  typedef enum logic [1:0] {
    ADDR_CNT_A = 2'd0,
    ADDR_CNT_B = 2'd1,
    ADDR_CTRL  = 2'd2,
    ADDR_PEND  = 2'd3
  } reg_addr_e;

  // command bit positions, per timer: start at 2*i, halt at 2*i+1
  localparam int unsigned CMD_BITS_PER_TMR = 2;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned DIV = 120
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] presc_q;

  assign tick_o = en_i && (presc_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      presc_q <= '0;
    else if (clr_i)   presc_q <= '0;
    else if (en_i)    presc_q <= tick_o ? '0 : presc_q + 1'b1;
  end

  a_r5_presc_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    presc_q <= LAST);

  a_r6_presc_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(presc_q));

  a_r5_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (presc_q == '0));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV   = 120
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             start_i,
  input  logic             halt_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  tmr_prescaler #(.DIV(DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ld_i),
    .en_i   (run_q),
    .tick_o (tick)
  );

  // halt has priority over start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= 1'b0;
    else if (halt_i)  run_q <= 1'b0;
    else if (start_i) run_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = tick && !ld_i && (&cnt_q);
  assign run_o  = run_q;
  assign cnt_o  = cnt_q;

  a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !ld_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r6_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !ld_i) |=> $stable(cnt_q));

  a_r7_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));

  a_r10_halt_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && halt_i) |=> !run_q);
endmodule

// File: rtl/tmr_pending.sv
module tmr_pending #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  // a set on the same edge as a clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  a_r7_set_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_q & ~clr_i)) |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i)));
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV_A = 120,
  parameter int unsigned DIV_B = 1200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic [1:0]       pend_o,
  output logic             irq_o
);
  localparam int unsigned N = NUM_TMR;

  logic [N-1:0]       ld, start, halt, run, wrap, clr;
  logic [CNT_W-1:0]   cnt [N];
  logic [N-1:0]       pend;
  reg_addr_e          addr;

  assign addr = reg_addr_e'(addr_i);

  assign ld[0] = wr_i && (addr == ADDR_CNT_A);
  assign ld[1] = wr_i && (addr == ADDR_CNT_B);
  assign clr   = (wr_i && (addr == ADDR_PEND)) ? wdata_i[N-1:0] : '0;

  for (genvar i = 0; i < N; i++) begin : g_tmr
    localparam int unsigned DIV_I = (i == 0) ? DIV_A : DIV_B;

    assign start[i] = wr_i && (addr == ADDR_CTRL) && wdata_i[CMD_BITS_PER_TMR*i];
    assign halt[i]  = wr_i && (addr == ADDR_CTRL) && wdata_i[CMD_BITS_PER_TMR*i+1];

    tmr_counter #(.CNT_W(CNT_W), .DIV(DIV_I)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ld_i     (ld[i]),
      .ld_val_i (wdata_i),
      .start_i  (start[i]),
      .halt_i   (halt[i]),
      .run_o    (run[i]),
      .cnt_o    (cnt[i]),
      .wrap_o   (wrap[i])
    );
  end

  tmr_pending #(.N(N)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wrap),
    .clr_i  (clr),
    .pend_o (pend)
  );

  always_comb begin
    unique case (addr)
      ADDR_CNT_A: rdata_o = cnt[0];
      ADDR_CNT_B: rdata_o = cnt[1];
      ADDR_CTRL:  rdata_o = CNT_W'(run);
      ADDR_PEND:  rdata_o = CNT_W'(pend);
      default:    rdata_o = '0;
    endcase
  end

  assign pend_o = pend;
  assign irq_o  = |pend;

  a_r9_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wrap) |=> irq_o);
endmodule

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;
  localparam int unsigned DA = 120;
  localparam int unsigned DB = 1200;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [1:0]  pend_o;
  logic        irq_o;

  dual_interval_timer #(.CNT_W(16), .DIV_A(DA), .DIV_B(DB)) u_dual_interval_timer (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .rdata_o, .pend_o, .irq_o
  );

  always #10 clk_i = ~clk_i;

  typedef struct {
    bit          sel;   // 0: rdata_o, 1: {pend_o, irq_o}
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int unsigned cyc = 0;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      act = it.sel ? {13'b0, pend_o, irq_o} : rdata_o;
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk_i); #1;
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_i = 1'b0;
  endtask

  task automatic chk(input logic [1:0] a, input logic [15:0] e, input string tag);
    item_t it;
    addr_i = a;
    it.sel = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic chk_irq(input logic [1:0] p, input logic i, input string tag);
    item_t it;
    it.sel = 1'b1; it.exp = {13'b0, p, i}; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic wait_edge(input int unsigned t);
    while (cyc < t) begin
      @(posedge clk_i); #1;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned s, h, p, r, w;
    #35 rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R1 reset state
    chk(2'd0, 16'h0000, "R1 count A");
    chk(2'd1, 16'h0000, "R1 count B");
    chk(2'd2, 16'h0000, "R1 running");
    chk(2'd3, 16'h0000, "R1 pending");
    chk_irq(2'b00, 1'b0, "R1 irq");

    // R2 load and read back
    wr(2'd1, 16'h1234);
    chk(2'd1, 16'h1234, "R2 count B readback");
    wr(2'd0, 16'h0010);
    chk(2'd0, 16'h0010, "R2 count A readback");

    // R5/R3 start after load: first step exactly DA clocks later
    wr(2'd2, 16'h0001);
    s = cyc;
    chk(2'd2, 16'h0001, "R10 A running");
    wait_edge(s + DA - 1);
    chk(2'd0, 16'h0010, "R5 no early step");
    wait_edge(s + DA);
    chk(2'd0, 16'h0011, "R5 first step");
    wait_edge(s + 2*DA - 1);
    chk(2'd0, 16'h0011, "R3 period hold");
    wait_edge(s + 2*DA);
    chk(2'd0, 16'h0012, "R3 second step");

    // R6 halt mid-period, resume with the remainder
    wait_edge(s + 2*DA + 50);
    wr(2'd2, 16'h0002);
    h = cyc;
    p = h - (s + 2*DA);
    wait_edge(h + 300);
    chk(2'd0, 16'h0012, "R6 frozen while halted");
    wr(2'd2, 16'h0001);
    r = cyc;
    wait_edge(r + DA - p - 1);
    chk(2'd0, 16'h0012, "R6 resume before remainder");
    wait_edge(r + DA - p);
    chk(2'd0, 16'h0013, "R6 resume remainder step");

    // R7 reload while running, wrap of A
    wr(2'd0, 16'hFFFE);
    w = cyc;
    wait_edge(w + DA - 1);
    chk(2'd0, 16'hFFFE, "R5 reload running no early step");
    wait_edge(w + DA);
    chk(2'd0, 16'hFFFF, "R5 reload running first step");
    chk_irq(2'b00, 1'b0, "R7 no pending before wrap");
    wait_edge(w + 2*DA);
    chk(2'd0, 16'h0000, "R7 A wraps to zero");
    chk_irq(2'b01, 1'b1, "R7 R9 A pending and irq");
    wait_edge(w + 3*DA);
    chk(2'd0, 16'h0001, "R7 A continues after wrap");

    // R4 timer B rate and wrap
    wr(2'd1, 16'hFFFE);
    wr(2'd2, 16'h0004);
    s = cyc;
    wait_edge(s + DB - 1);
    chk(2'd1, 16'hFFFE, "R4 B before first step");
    wait_edge(s + DB);
    chk(2'd1, 16'hFFFF, "R4 B first step");
    wait_edge(s + 2*DB - 1);
    chk(2'd3, 16'h0001, "R7 B not pending yet");
    wait_edge(s + 2*DB);
    chk(2'd1, 16'h0000, "R7 B wraps to zero");
    chk(2'd3, 16'h0003, "R7 B pending bit1");

    // R8 write-one-to-clear, R9 irq
    wr(2'd3, 16'h0000);
    chk(2'd3, 16'h0003, "R8 zero write no effect");
    wr(2'd3, 16'h0001);
    chk(2'd3, 16'h0002, "R8 clear A only");
    chk_irq(2'b10, 1'b1, "R9 irq with B pending");
    wr(2'd3, 16'h0002);
    chk(2'd3, 16'h0000, "R8 clear B");
    chk_irq(2'b00, 1'b0, "R9 irq low");

    // R10 command priority
    chk(2'd2, 16'h0003, "R10 both running");
    wr(2'd2, 16'h0003);
    chk(2'd2, 16'h0002, "R10 halt wins A");
    wr(2'd2, 16'h0008);
    chk(2'd2, 16'h0000, "R10 halt B");
    wr(2'd2, 16'h0004);
    chk(2'd2, 16'h0002, "R10 start B only");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule